// File: doc/BRIEF.md
# Transfer Byte Counter

This block keeps track of how many bytes are still outstanding in a bus data transfer, and of the host memory address of the next byte to move. Control logic loads the remaining count one byte lane at a time, loads a start address, or zeroes the count with a clear command. A one-cycle commit strobe is raised once for each byte that has actually been accepted on the far side. Each commit takes one off the count and moves the address forward by one, so the address always names the byte that comes next.

Two sticky flags report the transfer state. One is set when the count reaches zero. The other is set when a commit arrives while nothing is left to transfer. Software clears either flag by writing a one to its clear bit. Each flag has an enable bit, and a single interrupt line is raised while any enabled flag is set. The logic that produces the commit strobe is outside this block.

Top module: `xfer_byte_counter`

## Requirements
- R1: After reset the count, the address, both flags, both enables and the interrupt are all zero.
- R2: When bit i of `cnt_byte_we` is high, `cnt_wdata` is written into byte lane i of the count (lane 0 = bits 7:0) at the next clock. Lanes that are not written keep their value.
- R3: A commit while the count is nonzero, with no count write or clear in the same cycle, lowers the count by one and raises the address by one (modulo 2^ADDR_W) at the next clock.
- R4: With no commit, no count write, no clear and no address load, the count and the address hold their values.
- R5: A commit while the count is zero, with no count write or clear in the same cycle, leaves the count at zero and the address unchanged, and sets the wrap flag.
- R6: The done flag is set in the cycle after the count changes from nonzero to zero, whether a commit or a clear caused the change.
- R7: `cnt_clear` zeroes the count and takes priority over byte writes. A commit in a cycle that has a count write or a clear moves neither the count nor the address.
- R8: `addr_load` loads `addr_wdata` at the next clock and overrides a commit step in the same cycle.
- R9: A count write or clear that leaves the count nonzero clears the done flag.
- R10: `st_clr` bit 0 clears the done flag and bit 1 clears the wrap flag. If a flag's set event happens in the same cycle, the set wins.
- R11: `irq_en_we` loads `irq_en_wdata` into the enables (bit 0 = done, bit 1 = wrap). `irq_o` is high while any flag is set and its enable is set.
- R12: A flag stays set until one of its clear conditions occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_byte_we | input | 3 | Per-lane write strobes for the count |
| cnt_wdata | input | 8 | Byte written into the selected count lanes |
| cnt_clear | input | 1 | Zero the count |
| addr_load | input | 1 | Load the address |
| addr_wdata | input | 32 | New address value |
| commit | input | 1 | One byte safely transferred |
| irq_en_we | input | 1 | Write strobe for the interrupt enables |
| irq_en_wdata | input | 2 | Enables: bit 0 done, bit 1 wrap |
| st_clr | input | 2 | Write-one-to-clear: bit 0 done, bit 1 wrap |
| count_o | output | 24 | Remaining byte count |
| addr_o | output | 32 | Address of the next byte |
| done_o | output | 1 | Sticky count-reached-zero flag |
| wrap_o | output | 1 | Sticky commit-at-zero flag |
| irq_o | output | 1 | Combined gated interrupt |

## Verification
The bench builds the block with its default widths: a 24-bit count in three byte lanes and a 32-bit address. Because the count is written lane by lane, small counts can be loaded and driven to zero in a few commits. This exercises the done and wrap transitions without counting down from large values. Loading the address with its all-ones value brings the address roll-over within one commit. Same-cycle collisions are also driven: clear against write against commit, address load against a commit step, and a flag clear against a set.

// File: rtl/xbc_pkg.sv
package xbc_pkg;
  localparam int unsigned NUM_FLAGS = 2;
  localparam int unsigned FLG_DONE  = 0;
  localparam int unsigned FLG_WRAP  = 1;

  typedef struct packed {
    logic dec;        // committed byte consumed one count
    logic wrap;       // commit arrived with nothing left
    logic zero_hit;   // count went from nonzero to zero
    logic loaded_nz;  // count written/cleared to a nonzero value
  } xbc_events_t;
endpackage

// File: rtl/xbc_count.sv
module xbc_count
  import xbc_pkg::*;
#(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned NB    = (CNT_W + BYTE_W - 1) / BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NB-1:0]     byte_we,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              clear,
  input  logic              commit,
  output logic [CNT_W-1:0]  count,
  output xbc_events_t       ev
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  function automatic logic [CNT_W-1:0] merge_lanes(
    input logic [CNT_W-1:0]  cur,
    input logic [NB-1:0]     we,
    input logic [BYTE_W-1:0] d);
    logic [CNT_W-1:0] r;
    r = cur;
    for (int i = 0; i < int'(NB); i++) begin
      for (int b = 0; b < int'(BYTE_W); b++) begin
        if (we[i] && (i * int'(BYTE_W) + b < int'(CNT_W)))
          r[i * int'(BYTE_W) + b] = d[b];
      end
    end
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] cur);
    return (cur == '0) ? '0 : cur - ONE;
  endfunction

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic wr_any, quiet, is_zero;

  assign wr_any  = |byte_we;
  assign quiet   = !clear && !wr_any;
  assign is_zero = (cnt_q == '0);

  always_comb begin
    if (clear)       cnt_d = '0;
    else if (wr_any) cnt_d = merge_lanes(cnt_q, byte_we, wdata);
    else if (commit) cnt_d = step_down(cnt_q);
    else             cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ev.dec       = commit && quiet && !is_zero;
  assign ev.wrap      = commit && quiet && is_zero;
  assign ev.zero_hit  = !is_zero && (cnt_d == '0);
  assign ev.loaded_nz = !quiet && (cnt_d != '0);
  assign count        = cnt_q;
endmodule

// File: rtl/xbc_addr.sv
module xbc_addr #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);
  function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a);
    return a + {{(ADDR_W-1){1'b0}}, 1'b1};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= wdata;
    else if (step) addr <= next_addr(addr);
  end
endmodule

// File: rtl/xbc_flag.sv
module xbc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/xbc_status.sv
module xbc_status #(
  parameter int unsigned NF = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set,
  input  logic [NF-1:0] clr,
  input  logic          en_we,
  input  logic [NF-1:0] en_wdata,
  output logic [NF-1:0] flags,
  output logic          irq
);
  logic [NF-1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= en_wdata;
  end

  for (genvar g = 0; g < int'(NF); g++) begin : g_flag
    xbc_flag u_flag (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (set[g]),
      .clr  (clr[g]),
      .flag (flags[g])
    );
  end

  assign irq = |(flags & en_q);
endmodule

// File: rtl/xfer_byte_counter.sv
module xfer_byte_counter
  import xbc_pkg::*;
#(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned NB    = (CNT_W + BYTE_W - 1) / BYTE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NB-1:0]        cnt_byte_we,
  input  logic [BYTE_W-1:0]    cnt_wdata,
  input  logic                 cnt_clear,
  input  logic                 addr_load,
  input  logic [ADDR_W-1:0]    addr_wdata,
  input  logic                 commit,
  input  logic                 irq_en_we,
  input  logic [NUM_FLAGS-1:0] irq_en_wdata,
  input  logic [NUM_FLAGS-1:0] st_clr,
  output logic [CNT_W-1:0]     count_o,
  output logic [ADDR_W-1:0]    addr_o,
  output logic                 done_o,
  output logic                 wrap_o,
  output logic                 irq_o
);
  xbc_events_t          ev;
  logic                 dec_ev, wrap_ev;
  logic [NUM_FLAGS-1:0] flag_set, flag_clr, flags;

  xbc_count #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .byte_we(cnt_byte_we),
    .wdata  (cnt_wdata),
    .clear  (cnt_clear),
    .commit (commit),
    .count  (count_o),
    .ev     (ev)
  );

  assign dec_ev  = ev.dec;
  assign wrap_ev = ev.wrap;

  xbc_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk  (clk),
    .rst_n(rst_n),
    .load (addr_load),
    .wdata(addr_wdata),
    .step (dec_ev),
    .addr (addr_o)
  );

  always_comb begin
    flag_set           = '0;
    flag_clr           = st_clr;
    flag_set[FLG_DONE] = ev.zero_hit;
    flag_set[FLG_WRAP] = wrap_ev;
    flag_clr[FLG_DONE] = st_clr[FLG_DONE] | ev.loaded_nz;
  end

  xbc_status #(.NF(NUM_FLAGS)) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .set     (flag_set),
    .clr     (flag_clr),
    .en_we   (irq_en_we),
    .en_wdata(irq_en_wdata),
    .flags   (flags),
    .irq     (irq_o)
  );

  assign done_o = flags[FLG_DONE];
  assign wrap_o = flags[FLG_WRAP];
endmodule

// File: rtl/xfer_byte_counter_chk.sv
module xfer_byte_counter_chk #(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned NB     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NB-1:0]     cnt_byte_we,
  input logic              cnt_clear,
  input logic              commit,
  input logic              addr_load,
  input logic [1:0]        st_clr,
  input logic [CNT_W-1:0]  count_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              done_o,
  input logic              wrap_o,
  input logic              irq_o,
  input logic              dec_ev,
  input logic              wrap_ev
);
  localparam logic [CNT_W-1:0]  C1 = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [ADDR_W-1:0] A1 = {{(ADDR_W-1){1'b0}}, 1'b1};

  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_ev |=> (count_o + C1) == $past(count_o));

  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_ev && !addr_load) |=> addr_o == $past(addr_o) + A1);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !cnt_clear && cnt_byte_we == '0 && !addr_load)
      |=> ($stable(count_o) && $stable(addr_o)));

  p_wrap_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && count_o == '0 && !cnt_clear && cnt_byte_we == '0)
      |=> (wrap_o && count_o == '0));

  p_wrap_only_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_ev |-> (count_o == '0 && !dec_ev));

  p_done_on_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == '0 && $past(count_o) != '0) |-> done_o);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear |=> count_o == '0);

  p_irq_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (done_o || wrap_o));

  p_done_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !st_clr[0] && !cnt_clear && cnt_byte_we == '0) |=> done_o);

  p_wrap_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_o && !st_clr[1]) |=> wrap_o);
endmodule

bind xfer_byte_counter xfer_byte_counter_chk #(
  .CNT_W(CNT_W), .ADDR_W(ADDR_W), .NB(NB)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cnt_byte_we(cnt_byte_we),
  .cnt_clear  (cnt_clear),
  .commit     (commit),
  .addr_load  (addr_load),
  .st_clr     (st_clr),
  .count_o    (count_o),
  .addr_o     (addr_o),
  .done_o     (done_o),
  .wrap_o     (wrap_o),
  .irq_o      (irq_o),
  .dec_ev     (dec_ev),
  .wrap_ev    (wrap_ev)
);

// File: tb/xfer_byte_counter_test.sv
module xfer_byte_counter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cnt_byte_we = '0;
  logic [7:0]  cnt_wdata = '0;
  logic        cnt_clear = 1'b0;
  logic        addr_load = 1'b0;
  logic [31:0] addr_wdata = '0;
  logic        commit = 1'b0;
  logic        irq_en_we = 1'b0;
  logic [1:0]  irq_en_wdata = '0;
  logic [1:0]  st_clr = '0;
  logic [23:0] count_o;
  logic [31:0] addr_o;
  logic        done_o, wrap_o, irq_o;

  always #10 clk = ~clk;

  xfer_byte_counter uut (
    .clk(clk), .rst_n(rst_n), .cnt_byte_we(cnt_byte_we), .cnt_wdata(cnt_wdata),
    .cnt_clear(cnt_clear), .addr_load(addr_load), .addr_wdata(addr_wdata),
    .commit(commit), .irq_en_we(irq_en_we), .irq_en_wdata(irq_en_wdata),
    .st_clr(st_clr), .count_o(count_o), .addr_o(addr_o), .done_o(done_o),
    .wrap_o(wrap_o), .irq_o(irq_o)
  );

  typedef struct {
    logic [23:0] c;
    logic [31:0] a;
    logic        d, w, i;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference state, kept as plain integers
  int unsigned m_cnt = 0;
  longint unsigned m_addr = 0;
  bit m_done = 0, m_wrap = 0, m_en_d = 0, m_en_w = 0;

  task automatic compare(input exp_t e);
    checks++;
    if (count_o !== e.c || addr_o !== e.a || done_o !== e.d || wrap_o !== e.w || irq_o !== e.i) begin
      errors++;
      $display("FAIL %s: got cnt=%h addr=%h done=%b wrap=%b irq=%b, expected cnt=%h addr=%h done=%b wrap=%b irq=%b",
               e.tag, count_o, addr_o, done_o, wrap_o, irq_o, e.c, e.a, e.d, e.w, e.i);
    end
  endtask

  task automatic step(input logic [2:0] bwe, input logic [7:0] wd, input bit clr,
                      input bit al, input logic [31:0] awd, input bit cm,
                      input bit enwe, input logic [1:0] enwd, input logic [1:0] sclr,
                      input string tag);
    int unsigned nc;
    bit wr_any, moved, wrapped, hit, ldnz;
    exp_t e;
    @(negedge clk);
    cnt_byte_we = bwe; cnt_wdata = wd; cnt_clear = clr; addr_load = al;
    addr_wdata = awd; commit = cm; irq_en_we = enwe; irq_en_wdata = enwd; st_clr = sclr;
    wr_any = (bwe != 3'b000);
    nc = m_cnt;
    if (clr) nc = 0;
    else if (wr_any) begin
      if (bwe[0]) nc = (nc & 32'hFFFF00) | wd;
      if (bwe[1]) nc = (nc & 32'hFF00FF) | (int'(wd) << 8);
      if (bwe[2]) nc = (nc & 32'h00FFFF) | (int'(wd) << 16);
    end else if (cm && m_cnt > 0) nc = m_cnt - 1;
    moved   = cm && !clr && !wr_any && m_cnt > 0;
    wrapped = cm && !clr && !wr_any && m_cnt == 0;
    hit     = (m_cnt != 0) && (nc == 0);
    ldnz    = (clr || wr_any) && nc != 0;
    if (al) m_addr = awd;
    else if (moved) m_addr = (m_addr + 1) % 64'h1_0000_0000;
    if (hit) m_done = 1;
    else if (sclr[0] || ldnz) m_done = 0;
    if (wrapped) m_wrap = 1;
    else if (sclr[1]) m_wrap = 0;
    if (enwe) begin m_en_d = enwd[0]; m_en_w = enwd[1]; end
    m_cnt = nc;
    e.c = m_cnt[23:0]; e.a = m_addr[31:0]; e.d = m_done; e.w = m_wrap;
    e.i = (m_done && m_en_d) || (m_wrap && m_en_w);
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(3'b000, 8'h00, 0, 0, 32'h0, 0, 0, 2'b00, 2'b00, tag);
  endtask

  // monitor: pops one expectation per clock edge, just after the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) compare(exp_q.pop_front());
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state seen directly
    checks++;
    if (count_o !== 0 || addr_o !== 0 || done_o !== 0 || wrap_o !== 0 || irq_o !== 0) begin
      errors++;
      $display("FAIL R1: got cnt=%h addr=%h d=%b w=%b i=%b, expected all zero",
               count_o, addr_o, done_o, wrap_o, irq_o);
    end
    idle("R1 idle after reset");
    step(3'b001, 8'h03, 0, 0, 0, 0, 0, 0, 0, "R2 lane0 write");
    step(3'b010, 8'h01, 0, 0, 0, 0, 0, 0, 0, "R2 lane1 write");
    step(3'b100, 8'hA5, 0, 0, 0, 0, 0, 0, 0, "R2 lane2 write");
    step(3'b110, 8'h00, 0, 0, 0, 0, 0, 0, 0, "R2 two lanes");
    step(3'b000, 8'h00, 0, 1, 32'h0000_1000, 0, 1, 2'b01, 0, "R8 addr load, R11 enable done");
    step(3'b000, 8'h00, 0, 0, 0, 1, 0, 0, 0, "R3 commit 3->2");
    step(3'b000, 8'h00, 0, 0, 0, 1, 0, 0, 0, "R3 commit 2->1");
    step(3'b000, 8'h00, 0, 0, 0, 1, 0, 0, 0, "R6 R11 commit 1->0 done irq");
    idle("R4 R12 hold");
    step(3'b000, 8'h00, 0, 0, 0, 1, 0, 0, 0, "R5 commit at zero");
    step(3'b000, 8'h00, 0, 0, 0, 0, 0, 0, 2'b01, "R10 clear done, R11 wrap masked");
    step(3'b000, 8'h00, 0, 0, 0, 0, 1, 2'b10, 0, "R11 enable wrap");
    step(3'b000, 8'h00, 0, 0, 0, 1, 0, 0, 2'b10, "R10 set beats clear wrap");
    step(3'b000, 8'h00, 0, 0, 0, 0, 0, 0, 2'b10, "R10 clear wrap");
    step(3'b001, 8'h02, 0, 0, 0, 1, 0, 0, 0, "R7 write with commit");
    step(3'b000, 8'h00, 0, 1, 32'h0000_2000, 1, 0, 0, 0, "R8 load over step");
    step(3'b001, 8'h07, 1, 0, 0, 1, 0, 0, 0, "R6 R7 clear wins");
    step(3'b000, 8'h00, 0, 1, 32'hFFFF_FFFF, 0, 0, 0, 0, "R8 load top addr");
    step(3'b001, 8'h05, 0, 0, 0, 0, 0, 0, 0, "R9 load clears done");
    step(3'b000, 8'h00, 0, 0, 0, 1, 0, 0, 0, "R3 addr rollover");
    step(3'b001, 8'h01, 0, 0, 0, 0, 0, 0, 0, "R2 load one");
    step(3'b000, 8'h00, 0, 0, 0, 1, 0, 0, 2'b01, "R10 done set beats clear");
    step(3'b000, 8'h00, 1, 0, 0, 0, 0, 0, 0, "R12 clear at zero keeps done");
    idle("R4 final hold");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule